// File: doc/BRIEF.md
# Channel-Aware Sampling Sequencer for a Pipelined SPI ADC

This block drives a serial peripheral interface toward a multi-channel successive-approximation converter. The converter only applies a configuration word after a delay. The result shifted out during a frame belongs to the configuration that was written two frames earlier. A host asks for one sample from one channel. The sequencer issues as many chip-select frames as that delay needs, so that the word it returns was acquired with the requested channel on the converter's input mux. The earlier, stale words are thrown away.

The block remembers which channel it last programmed. When a request names that same channel, one configuration frame and one read frame are enough. When the request names a different channel, or is the first request since reset, a second configuration frame goes out as a dummy before the read frame. Read frames transmit all zeros. After each frame, chip select stays high for a programmable number of clock cycles so that the converter can finish its conversion.

The request side uses a valid/ready handshake. A request is taken on a cycle where both `req_valid` and `req_ready` are high. While a request is in flight, `req_ready` stays low and `req_valid` is ignored, so the host applies back-pressure simply by holding its request. The result side has no back-pressure: `rsp_valid` is a single-cycle strobe that the consumer must capture.

Top module: `adc_rd_seq`

## Requirements
- R1: While reset is held and on the first cycle after it, `spi_cs_n` is 1, `spi_sclk` is 0, `busy` is 0, `req_ready` is 1 and `rsp_valid` is 0.
- R2: The bus works in mode 0. `spi_sclk` is low whenever `spi_cs_n` is high. Each frame has exactly WORD_W rising clock edges. MOSI is shifted most significant bit first, and MISO is captured on rising edges, also most significant bit first.
- R3: Once `spi_cs_n` rises, it stays high for at least CONV_CYC clock cycles before the next frame begins.
- R4: If the requested channel differs from the channel last programmed, or no channel has been programmed since reset, the request runs exactly three frames: configuration word, the same configuration word again, then a frame of all zeros.
- R5: If the requested channel equals the channel last programmed, the request runs exactly two frames: the configuration word, then a frame of all zeros.
- R6: The configuration word is CFG_BASE with the bit field [CH_LSB +: CH_W] replaced by the channel number. Bit WORD_W-1 of CFG_BASE is 1, and this marks the word as a configuration update. An all-zero word does not change the converter's configuration.
- R7: The result is the MISO word of the request's final frame, keeping only its low RES bits. It is presented on `rsp_data` with `rsp_valid` high for exactly one cycle.
- R8: A request is accepted only when `req_ready` is high. `req_ready` is low while `busy` is high. A request signalled while busy has no effect on the channel, the frames or the result.
- R9: The returned sample was acquired by the converter with the requested channel selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Sample request present |
| req_ready | output | 1 | Sequencer can accept a request |
| req_ch | input | CH_W | Channel to sample, taken at handshake |
| busy | output | 1 | A request is in progress |
| rsp_valid | output | 1 | One-cycle strobe marking a result |
| rsp_data | output | RES | Result masked to RES bits |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data to the converter |
| spi_miso | input | 1 | Serial data from the converter |

## Verification
The assertions assume that CONV_CYC and DIV are both at least 1, and that `req_ch` matters only on a handshake cycle. They make no assumption about MISO beyond its being a defined level. The stimulus pulses `req_valid` on cycles where `req_ready` is high. It also holds `req_valid` high with a different channel while a request is in flight, which checks that such requests are ignored. A converter model in the bench has the same two-frame configuration pipeline. It honours the update flag and returns words whose upper bits are set, so that masking can be seen, with the acquired channel encoded in the result. Requests sweep every ordered pair of channels, which exercises both the repeat path and the change path.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
  typedef enum logic [1:0] {FR_IDLE, FR_SHIFT, FR_GAP} fr_state_t;
  typedef enum logic [1:0] {SQ_IDLE, SQ_CFG, SQ_DUMMY, SQ_READ} sq_state_t;
endpackage

// File: rtl/adc_spi_frame.sv
module adc_spi_frame
  import adc_rd_pkg::*;
#(
  parameter int W        = 16,
  parameter int DIV      = 4,
  parameter int CONV_CYC = 40
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] tx_word,
  output logic         idle,
  output logic         done,
  output logic [W-1:0] rx_word,
  output logic         cs_n,
  output logic         sclk,
  output logic         mosi,
  input  logic         miso
);
  localparam int DW = $clog2(DIV + 1);
  localparam int BW = $clog2(W + 1);
  localparam int GW = $clog2(CONV_CYC + 2);

  fr_state_t      st;
  logic [DW-1:0]  div_cnt;
  logic [BW-1:0]  bit_cnt;
  logic [GW-1:0]  gap_cnt;
  logic [W-1:0]   tx_sh;
  logic [W-1:0]   rx_sh;

  assign idle    = (st == FR_IDLE);
  assign rx_word = rx_sh;
  assign mosi    = cs_n ? 1'b0 : tx_sh[W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= FR_IDLE;
      div_cnt <= '0;
      bit_cnt <= '0;
      gap_cnt <= '0;
      tx_sh   <= '0;
      rx_sh   <= '0;
      cs_n    <= 1'b1;
      sclk    <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (st)
        FR_IDLE: if (start) begin
          st      <= FR_SHIFT;
          cs_n    <= 1'b0;
          sclk    <= 1'b0;
          tx_sh   <= tx_word;
          div_cnt <= '0;
          bit_cnt <= '0;
        end
        FR_SHIFT: begin
          if (div_cnt == DW'(DIV - 1)) begin
            div_cnt <= '0;
            if (!sclk) begin
              sclk  <= 1'b1;
              rx_sh <= {rx_sh[W-2:0], miso};
            end else begin
              sclk <= 1'b0;
              if (bit_cnt == BW'(W - 1)) begin
                st      <= FR_GAP;
                cs_n    <= 1'b1;
                done    <= 1'b1;
                gap_cnt <= '0;
              end else begin
                bit_cnt <= bit_cnt + 1'b1;
                tx_sh   <= {tx_sh[W-2:0], 1'b0};
              end
            end
          end else begin
            div_cnt <= div_cnt + 1'b1;
          end
        end
        FR_GAP: begin
          if (gap_cnt == GW'(CONV_CYC - 1)) st <= FR_IDLE;
          else gap_cnt <= gap_cnt + 1'b1;
        end
        default: st <= FR_IDLE;
      endcase
    end
  end

  // counts cycles with chip select high, saturating, for the conversion-time check
  logic [GW-1:0] hi_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_cnt <= GW'(CONV_CYC);
    else if (!cs_n) hi_cnt <= '0;
    else if (hi_cnt < GW'(CONV_CYC)) hi_cnt <= hi_cnt + 1'b1;
  end

  AST_SCLK_LOW_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk); // R2
  AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (idle && cs_n)); // R2
  AST_CONV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (start && idle) |-> (hi_cnt >= GW'(CONV_CYC))); // R3
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_rd_pkg::*;
#(
  parameter int                WORD_W   = 16,
  parameter int                RES      = 16,
  parameter int                CH_W     = 3,
  parameter int                CH_LSB   = 7,
  parameter logic [WORD_W-1:0] CFG_BASE = 16'hB1C4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [CH_W-1:0]   req_ch,
  output logic              busy,
  output logic              rsp_valid,
  output logic [RES-1:0]    rsp_data,
  output logic              fr_start,
  output logic [WORD_W-1:0] fr_tx,
  input  logic              fr_idle,
  input  logic              fr_done,
  input  logic [WORD_W-1:0] fr_rx
);
  localparam logic [WORD_W-1:0] CH_FIELD = WORD_W'({CH_W{1'b1}}) << CH_LSB;
  localparam logic [CH_W:0]     CH_NONE  = {1'b1, {CH_W{1'b0}}};

  sq_state_t         st;
  logic              launched;
  logic              need_dummy;
  logic [CH_W-1:0]   tgt_ch;
  logic [CH_W:0]     cur_ch;
  logic [WORD_W-1:0] cfg_word;

  assign cfg_word  = (CFG_BASE & ~CH_FIELD) | (WORD_W'(tgt_ch) << CH_LSB);
  assign req_ready = (st == SQ_IDLE);
  assign busy      = !req_ready;
  assign fr_start  = busy && !launched && fr_idle;
  assign fr_tx     = (st == SQ_READ) ? '0 : cfg_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= SQ_IDLE;
      launched   <= 1'b0;
      need_dummy <= 1'b0;
      tgt_ch     <= '0;
      cur_ch     <= CH_NONE;
      rsp_valid  <= 1'b0;
      rsp_data   <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (fr_start) launched <= 1'b1;
      else if (fr_done) launched <= 1'b0;
      unique case (st)
        SQ_IDLE: if (req_valid) begin
          tgt_ch     <= req_ch;
          need_dummy <= (cur_ch != {1'b0, req_ch});
          st         <= SQ_CFG;
        end
        SQ_CFG: if (fr_done) begin
          cur_ch <= {1'b0, tgt_ch};
          st     <= need_dummy ? SQ_DUMMY : SQ_READ;
        end
        SQ_DUMMY: if (fr_done) st <= SQ_READ;
        SQ_READ: if (fr_done) begin
          rsp_valid <= 1'b1;
          rsp_data  <= fr_rx[RES-1:0];
          st        <= SQ_IDLE;
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end

  AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R7
  AST_ACCEPT_GOES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> busy); // R8
  AST_TARGET_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(tgt_ch)); // R8
  AST_CUR_MATCHES_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (cur_ch == {1'b0, tgt_ch})); // R9
endmodule

// File: rtl/adc_rd_seq.sv
module adc_rd_seq #(
  parameter int                WORD_W   = 16,
  parameter int                RES      = 16,
  parameter int                CH_W     = 3,
  parameter int                CH_LSB   = 7,
  parameter logic [WORD_W-1:0] CFG_BASE = 16'hB1C4,
  parameter int                DIV      = 4,
  parameter int                CONV_CYC = 40
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [CH_W-1:0] req_ch,
  output logic            busy,
  output logic            rsp_valid,
  output logic [RES-1:0]  rsp_data,
  output logic            spi_cs_n,
  output logic            spi_sclk,
  output logic            spi_mosi,
  input  logic            spi_miso
);
  logic              fr_start;
  logic [WORD_W-1:0] fr_tx;
  logic              fr_idle;
  logic              fr_done;
  logic [WORD_W-1:0] fr_rx;

  adc_seq_ctrl #(
    .WORD_W(WORD_W), .RES(RES), .CH_W(CH_W), .CH_LSB(CH_LSB), .CFG_BASE(CFG_BASE)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_ch(req_ch), .busy(busy),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .fr_start(fr_start), .fr_tx(fr_tx), .fr_idle(fr_idle),
    .fr_done(fr_done), .fr_rx(fr_rx)
  );

  adc_spi_frame #(.W(WORD_W), .DIV(DIV), .CONV_CYC(CONV_CYC)) u_frame (
    .clk(clk), .rst_n(rst_n),
    .start(fr_start), .tx_word(fr_tx), .idle(fr_idle), .done(fr_done),
    .rx_word(fr_rx), .cs_n(spi_cs_n), .sclk(spi_sclk),
    .mosi(spi_mosi), .miso(spi_miso)
  );

  AST_NO_FRAME_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy)) |-> spi_cs_n); // R8
endmodule

// File: tb/sim_adc_rd_seq.sv
module sim_adc_rd_seq;
  localparam int CLK_PERIOD = 10;
  localparam int WW  = 16;
  localparam int RES = 14;
  localparam int CONV = 6;
  localparam logic [15:0] BASE = 16'hB1C4;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0;
  logic [2:0] req_ch = '0;
  logic req_ready, busy, rsp_valid, cs_n, sclk, mosi, miso;
  logic [RES-1:0] rsp_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_rd_seq #(.WORD_W(WW), .RES(RES), .CH_W(3), .CH_LSB(7), .CFG_BASE(BASE),
               .DIV(2), .CONV_CYC(CONV)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_ch(req_ch), .busy(busy), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .spi_cs_n(cs_n), .spi_sclk(sclk), .spi_mosi(mosi), .spi_miso(miso));

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // converter model: data in frame K comes from the configuration written in frame K-2
  logic [15:0] m_word = '0, m_out = '0, m_rx = '0;
  logic [15:0] fw [8];
  logic [15:0] shifted [8];
  int m_idx = 0, m_frames = 0, m_badlen = 0, m_seq = 0;
  logic [2:0] acq_ch = '0;
  logic m_cs_q = 1'b1;

  assign miso = (cs_n || m_idx > 15) ? 1'b0 : m_word[15 - m_idx];

  always @(cs_n or posedge sclk) begin
    if (rst_n === 1'b1) begin
      if (cs_n !== m_cs_q) begin
        if (cs_n === 1'b0) begin
          m_word = m_out; m_idx = 0; m_rx = '0;
        end else begin
          if (m_idx != 16) m_badlen++;
          fw[m_frames % 8] = m_rx;
          shifted[m_frames % 8] = m_word;
          m_frames++;
          m_out = {2'b11, acq_ch, m_seq[10:0]};
          m_seq++;
          if (m_rx[15]) acq_ch = m_rx[9:7];
        end
        m_cs_q = cs_n;
      end else if (sclk === 1'b1 && cs_n === 1'b0) begin
        m_rx = {m_rx[14:0], mosi};
        m_idx++;
      end
    end
  end

  // conversion gap and idle-clock observation
  int hi_cnt = 0, min_gap = 1000000, sclk_bad = 0;
  bit seen_frame = 0;
  always @(posedge clk) begin
    if (rst_n) begin
      if (cs_n && sclk) sclk_bad++;
      if (cs_n) hi_cnt++;
      else begin
        if (hi_cnt > 0 && seen_frame && hi_cnt < min_gap) min_gap = hi_cnt;
        if (hi_cnt > 0) seen_frame = 1;
        hi_cnt = 0;
      end
    end
  end

  function automatic logic [15:0] cfg_of(input int ch);
    return (BASE & ~(16'h7 << 7)) | (16'(ch) << 7);
  endfunction

  int cur = -1;

  task automatic do_req(input int ch, input bit poke_busy);
    int f0, nf, w;
    bit got;
    @(negedge clk);
    chk("R8 ready before request", {31'd0, req_ready}, 32'd1);
    f0 = m_frames;
    req_valid = 1; req_ch = 3'(ch);
    @(negedge clk);
    if (poke_busy) begin
      req_ch = 3'(ch ^ 5);
      chk("R8 ready low while busy", {31'd0, req_ready}, 32'd0);
      repeat (30) @(negedge clk);
    end
    req_valid = 0;
    got = 0;
    for (int i = 0; i < 4000 && !got; i++) begin
      if (rsp_valid) got = 1; else @(negedge clk);
    end
    chk("R7 result strobe", {31'd0, got}, 32'd1);
    nf = m_frames - f0;
    w  = (m_frames - 1) % 8;
    chk("R7 masked final-frame data", {18'd0, rsp_data}, {18'd0, shifted[w][13:0]});
    chk("R9 acquired channel", {29'd0, rsp_data[13:11]}, 32'(ch));
    if (cur != ch) begin
      chk("R4 frame count on change", 32'(nf), 32'd3);
      chk("R6 R4 first config word", {16'd0, fw[f0 % 8]}, {16'd0, cfg_of(ch)});
      chk("R6 R4 dummy config word", {16'd0, fw[(f0 + 1) % 8]}, {16'd0, cfg_of(ch)});
    end else begin
      chk("R5 frame count on repeat", 32'(nf), 32'd2);
      chk("R6 R5 config word", {16'd0, fw[f0 % 8]}, {16'd0, cfg_of(ch)});
    end
    chk("R4 R5 read frame zeros", {16'd0, fw[w]}, 32'd0);
    @(negedge clk);
    chk("R7 strobe one cycle", {31'd0, rsp_valid}, 32'd0);
    cur = ch;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 cs_n in reset", {31'd0, cs_n}, 32'd1);
    chk("R1 sclk in reset", {31'd0, sclk}, 32'd0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 cs_n after reset", {31'd0, cs_n}, 32'd1);
    chk("R1 busy after reset", {31'd0, busy}, 32'd0);
    chk("R1 ready after reset", {31'd0, req_ready}, 32'd1);
    chk("R1 rsp_valid after reset", {31'd0, rsp_valid}, 32'd0);
    do_req(0, 0);
    do_req(0, 0);
    for (int a = 0; a < 8; a++)
      for (int b = 0; b < 8; b++) begin
        do_req(a, 0);
        do_req(b, (a == 3 && b == 6));
      end
    do_req(2, 1);
    do_req(2, 1);
    repeat (20) @(negedge clk);
    chk("R8 no frame while idle", {31'd0, cs_n}, 32'd1);
    chk("R2 bits per frame", 32'(m_badlen), 32'd0);
    chk("R2 sclk low with cs high", 32'(sclk_bad), 32'd0);
    chk("R3 conversion hold", {31'd0, min_gap >= CONV}, 32'd1);
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule